// File: doc/BRIEF.md
# Serial Interface Block-Copy Controller

This controller connects a host bus to a small command and response RAM of 64 bytes, kept as 16 big-endian words. The host programs a system-memory base address. It then writes one of two trigger registers. The pull trigger fills the RAM from system memory and keeps a snapshot of the result as the command buffer. The push trigger first hands the RAM to an external command processor. When the processor reports completion, the controller copies the RAM out to system memory. System memory is reached through a word-wide request/acknowledge port, one word per handshake.

When a copy finishes, or when the host writes a RAM word, the controller sets a pending flag that drives the interrupt line. Any write to the status register clears it. The host can also read and write the RAM directly. Writes to the RAM use a per-byte keep mask. Two offsets have side behaviour: a read at 0x3C returns an internal status byte, and a read at 0x24 sets that byte to 0x80.

Top module: `sidma_ctrl`

## Requirements
- R1: After reset, irq and mem_req are 0, the status register reads 0 and a RAM read at offset 0x3C returns 0.
- R2: Any host write to register offset 0xC (status) clears the pending flag (status bit 12) and irq in the next cycle, whatever the data and mask.
- R3: A host RAM write (host_sel=1) merges the data per byte: if host_bmask[i] is 1, bits 8i+7:8i keep their old value; otherwise they take the new data. The write sets the pending flag. While a copy is busy, the write is ignored and sets nothing.
- R4: The RAM offset is host_addr & 0x3F, so higher address bits are ignored. RAM byte 0 is bits 31:24 of the word at offset 0, and it is bits 511:504 of cmd_snap.
- R5: A host read returns host_rdata with host_rvalid one cycle after the request. A RAM read at 0x24 returns the RAM word and sets the status byte to 0x80. A RAM read at 0x3C returns {24'h0, status byte} instead of RAM contents.
- R6: A write to register offset 0x4 (pull) reads 16 words from (base & 0x1FFFFFFF) + 4k, for k ascending, into RAM word k. It then copies the RAM to cmd_snap and sets the pending flag one cycle after the last acknowledge.
- R7: A write to register offset 0x8 (push) holds cmd_go high with no memory traffic until cmd_done. While cmd_go is high, cmd_wr writes RAM words. After cmd_done, the controller writes RAM word k to base + 4k for k = 0..15 and then sets the pending flag.
- R8: Status bit 0 reads 1 while a copy is in progress. A trigger written while busy is ignored.
- R9: A write to register offset 0x0 (base address) replaces each byte whose host_bmask bit is 1. The register reads back as stored, and reads of the trigger offsets return 0.
- R10: mem_req, once raised, stays high with stable mem_addr and mem_wdata until mem_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Host access request, one cycle |
| host_we | input | 1 | 1 = write, 0 = read |
| host_sel | input | 1 | 0 = registers, 1 = command RAM |
| host_addr | input | 32 | Host byte address |
| host_wdata | input | 32 | Host write data |
| host_bmask | input | 4 | Byte mask (replace for registers, keep for RAM) |
| host_rdata | output | 32 | Read data |
| host_rvalid | output | 1 | Read data valid |
| irq | output | 1 | Interrupt, follows the pending flag |
| mem_req | output | 1 | Memory port request |
| mem_we | output | 1 | Memory port write |
| mem_addr | output | 29 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |
| mem_ack | input | 1 | Memory handshake acknowledge |
| cmd_go | output | 1 | Command processing requested |
| cmd_done | input | 1 | Command processing finished |
| cmd_wr | input | 1 | Processor RAM write strobe |
| cmd_widx | input | 4 | Processor RAM word index |
| cmd_wdata | input | 32 | Processor RAM write data |
| cmd_snap | output | 512 | Command buffer snapshot, byte 0 in the top bits |

## Verification
Host writes take effect at the clock edge that samples them. Read data and host_rvalid appear one cycle after the request. The first memory request appears the cycle after a pull trigger, or the cycle after cmd_done for a push. The pending flag and irq rise one cycle after the final acknowledge. The bench drives every input on the falling edge and samples results on the next falling edge, so each sample lands after the register that produces the result has updated. Because the total length of a copy depends on the memory model's acknowledge spacing, the bench waits for irq with a bounded poll rather than counting a fixed number of cycles. It then checks the address order, the word counts and the data.

// File: rtl/sidma_pkg.sv
package sidma_pkg;
    localparam int WORD_W = 32;
    localparam int LANES  = WORD_W / 8;

    localparam logic [1:0] REG_BASE = 2'd0;
    localparam logic [1:0] REG_PULL = 2'd1;
    localparam logic [1:0] REG_PUSH = 2'd2;
    localparam logic [1:0] REG_STAT = 2'd3;

    localparam int PEND_BIT = 12;
    localparam int BUSY_BIT = 0;

    localparam int         OFS_ARM      = 'h24;
    localparam int         OFS_SBYTE    = 'h3C;
    localparam logic [7:0] SBYTE_ARMED  = 8'h80;

    typedef enum logic [1:0] {MV_IDLE, MV_CMD, MV_XFER, MV_FIN} mv_state_e;
    typedef enum logic {DIR_PULL, DIR_PUSH} mv_dir_e;

    // Lane i set: keep old byte.
    function automatic logic [WORD_W-1:0] merge_keep(input logic [WORD_W-1:0] old_w,
                                                     input logic [WORD_W-1:0] new_w,
                                                     input logic [LANES-1:0] keep);
        logic [WORD_W-1:0] r;
        for (int i = 0; i < LANES; i++)
            r[8*i +: 8] = keep[i] ? old_w[8*i +: 8] : new_w[8*i +: 8];
        return r;
    endfunction

    // Lane i set: take new byte.
    function automatic logic [WORD_W-1:0] merge_take(input logic [WORD_W-1:0] old_w,
                                                     input logic [WORD_W-1:0] new_w,
                                                     input logic [LANES-1:0] take);
        return merge_keep(old_w, new_w, ~take);
    endfunction
endpackage

// File: rtl/sidma_ram.sv
module sidma_ram
    import sidma_pkg::*;
#(
    parameter int WORDS = 16,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    host_wr,
    input  logic [IDX_W-1:0]        host_idx,
    input  logic [WORD_W-1:0]       host_wdata,
    input  logic [LANES-1:0]        host_keep,
    input  logic                    dma_wr,
    input  logic [IDX_W-1:0]        dma_idx,
    input  logic [WORD_W-1:0]       dma_wdata,
    input  logic                    cmd_wr,
    input  logic [IDX_W-1:0]        cmd_idx,
    input  logic [WORD_W-1:0]       cmd_wdata,
    input  logic                    snap_en,
    output logic [WORD_W-1:0]       host_rword,
    output logic [WORD_W-1:0]       dma_rword,
    output logic [WORDS*WORD_W-1:0] snap
);
    logic [WORD_W-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= '0;
        end else if (dma_wr) begin
            mem[dma_idx] <= dma_wdata;
        end else if (cmd_wr) begin
            mem[cmd_idx] <= cmd_wdata;
        end else if (host_wr) begin
            mem[host_idx] <= merge_keep(mem[host_idx], host_wdata, host_keep);
        end
    end

    assign host_rword = mem[host_idx];
    assign dma_rword  = mem[dma_idx];

    // Word 0 lands in the top bits so byte 0 is the most significant byte.
    for (genvar g = 0; g < WORDS; g++) begin : g_snap
        always_ff @(posedge clk) begin
            if (rst)          snap[(WORDS-1-g)*WORD_W +: WORD_W] <= '0;
            else if (snap_en) snap[(WORDS-1-g)*WORD_W +: WORD_W] <= mem[g];
        end
    end

    AST_ONE_WRITER: assert property (@(posedge clk) disable iff (rst)
        $countones({dma_wr, cmd_wr, host_wr}) <= 1); // R3
endmodule

// File: rtl/sidma_mover.sv
module sidma_mover
    import sidma_pkg::*;
#(
    parameter int WORDS  = 16,
    parameter int MEM_AW = 29,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_pull,
    input  logic              start_push,
    input  logic [MEM_AW-1:0] base,
    input  logic              cmd_done,
    input  logic [WORD_W-1:0] ram_rword,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_ack,
    output logic              busy,
    output logic              done,
    output logic              snap_en,
    output logic              cmd_go,
    output logic              mem_req,
    output logic              mem_we,
    output logic [MEM_AW-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic [IDX_W-1:0]  idx,
    output logic              dma_wr,
    output logic [WORD_W-1:0] dma_wdata
);
    mv_state_e         state;
    mv_dir_e           dir;
    logic [MEM_AW-1:0] base_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= MV_IDLE;
            dir    <= DIR_PULL;
            base_q <= '0;
            idx    <= '0;
        end else begin
            case (state)
                MV_IDLE: begin
                    idx    <= '0;
                    base_q <= base;
                    if (start_pull) begin
                        dir   <= DIR_PULL;
                        state <= MV_XFER;
                    end else if (start_push) begin
                        dir   <= DIR_PUSH;
                        state <= MV_CMD;
                    end
                end
                MV_CMD: if (cmd_done) state <= MV_XFER;
                MV_XFER: if (mem_ack) begin
                    if (idx == IDX_W'(WORDS-1)) state <= MV_FIN;
                    else                        idx   <= idx + 1'b1;
                end
                default: state <= MV_IDLE;
            endcase
        end
    end

    assign busy      = (state != MV_IDLE);
    assign done      = (state == MV_FIN);
    assign snap_en   = done && (dir == DIR_PULL);
    assign cmd_go    = (state == MV_CMD);
    assign mem_req   = (state == MV_XFER);
    assign mem_we    = (dir == DIR_PUSH);
    assign mem_addr  = base_q + MEM_AW'({idx, 2'b00});
    assign mem_wdata = ram_rword;
    assign dma_wr    = mem_req && mem_ack && (dir == DIR_PULL);
    assign dma_wdata = mem_rdata;

    logic [IDX_W:0] ack_cnt;
    always_ff @(posedge clk) begin
        if (rst || state == MV_IDLE) ack_cnt <= '0;
        else if (mem_req && mem_ack) ack_cnt <= ack_cnt + 1'b1;
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_wdata)); // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_req && !cmd_go); // R8
    AST_ACK_TOTAL: assert property (@(posedge clk) disable iff (rst)
        done |-> ack_cnt == (IDX_W+1)'(WORDS)); // R6
    AST_NO_MEM_IN_CMD: assert property (@(posedge clk) disable iff (rst)
        cmd_go |-> !mem_req); // R7
endmodule

// File: rtl/sidma_regs.sv
module sidma_regs
    import sidma_pkg::*;
#(
    parameter int WORDS = 16,
    localparam int IDX_W = $clog2(WORDS),
    localparam int OFS_W = IDX_W + 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_req,
    input  logic              host_we,
    input  logic              host_sel,
    input  logic [31:0]       host_addr,
    input  logic [WORD_W-1:0] host_wdata,
    input  logic [LANES-1:0]  host_bmask,
    input  logic              busy,
    input  logic              done,
    input  logic [WORD_W-1:0] ram_rword,
    output logic              start_pull,
    output logic              start_push,
    output logic [WORD_W-1:0] base_q,
    output logic              irq,
    output logic [WORD_W-1:0] host_rdata,
    output logic              host_rvalid,
    output logic              ram_wr,
    output logic [IDX_W-1:0]  ram_idx
);
    logic [1:0]       reg_sel;
    logic [OFS_W-1:0] ofs;
    logic             wr_reg, rd_any, stat_wr;
    logic             pend;
    logic [7:0]       sbyte;
    logic [WORD_W-1:0] rd_val;

    assign reg_sel    = host_addr[3:2];
    assign ofs        = host_addr[OFS_W-1:0];
    assign ram_idx    = host_addr[OFS_W-1:2];
    assign wr_reg     = host_req && host_we && !host_sel;
    assign rd_any     = host_req && !host_we;
    assign stat_wr    = wr_reg && (reg_sel == REG_STAT);
    assign start_pull = wr_reg && (reg_sel == REG_PULL) && !busy;
    assign start_push = wr_reg && (reg_sel == REG_PUSH) && !busy;
    assign ram_wr     = host_req && host_we && host_sel && !busy;
    assign irq        = pend;

    always_comb begin
        rd_val = '0;
        if (host_sel) begin
            if (ofs == OFS_W'(OFS_SBYTE)) rd_val = {24'h0, sbyte};
            else                          rd_val = ram_rword;
        end else begin
            case (reg_sel)
                REG_BASE: rd_val = base_q;
                REG_STAT: begin
                    rd_val[PEND_BIT] = pend;
                    rd_val[BUSY_BIT] = busy;
                end
                default:  rd_val = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q      <= '0;
            pend        <= 1'b0;
            sbyte       <= '0;
            host_rdata  <= '0;
            host_rvalid <= 1'b0;
        end else begin
            host_rvalid <= rd_any;
            if (rd_any) host_rdata <= rd_val;
            if (rd_any && host_sel && ofs == OFS_W'(OFS_ARM)) sbyte <= SBYTE_ARMED;
            if (wr_reg && reg_sel == REG_BASE)
                base_q <= merge_take(base_q, host_wdata, host_bmask);
            if (done || ram_wr) pend <= 1'b1;
            else if (stat_wr)   pend <= 1'b0;
        end
    end

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        stat_wr && !done |=> !irq); // R2
    AST_DONE_RAISES: assert property (@(posedge clk) disable iff (rst)
        done |=> irq); // R6
    AST_HOST_WR_RAISES: assert property (@(posedge clk) disable iff (rst)
        host_req && host_we && host_sel && !busy |=> irq); // R3
    AST_RVALID: assert property (@(posedge clk) disable iff (rst)
        host_req && !host_we |=> host_rvalid); // R5
endmodule

// File: rtl/sidma_ctrl.sv
module sidma_ctrl
    import sidma_pkg::*;
#(
    parameter int WORDS  = 16,
    parameter int MEM_AW = 29,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    host_req,
    input  logic                    host_we,
    input  logic                    host_sel,
    input  logic [31:0]             host_addr,
    input  logic [WORD_W-1:0]       host_wdata,
    input  logic [LANES-1:0]        host_bmask,
    output logic [WORD_W-1:0]       host_rdata,
    output logic                    host_rvalid,
    output logic                    irq,
    output logic                    mem_req,
    output logic                    mem_we,
    output logic [MEM_AW-1:0]       mem_addr,
    output logic [WORD_W-1:0]       mem_wdata,
    input  logic [WORD_W-1:0]       mem_rdata,
    input  logic                    mem_ack,
    output logic                    cmd_go,
    input  logic                    cmd_done,
    input  logic                    cmd_wr,
    input  logic [IDX_W-1:0]        cmd_widx,
    input  logic [WORD_W-1:0]       cmd_wdata,
    output logic [WORDS*WORD_W-1:0] cmd_snap
);
    logic              start_pull, start_push, busy, done, snap_en;
    logic [WORD_W-1:0] base_q, host_rword, dma_rword, dma_wdata;
    logic              ram_wr, dma_wr;
    logic [IDX_W-1:0]  ram_idx, dma_idx;

    sidma_regs #(.WORDS(WORDS)) u_regs (
        .clk(clk), .rst(rst),
        .host_req(host_req), .host_we(host_we), .host_sel(host_sel),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_bmask(host_bmask),
        .busy(busy), .done(done), .ram_rword(host_rword),
        .start_pull(start_pull), .start_push(start_push), .base_q(base_q),
        .irq(irq), .host_rdata(host_rdata), .host_rvalid(host_rvalid),
        .ram_wr(ram_wr), .ram_idx(ram_idx)
    );

    sidma_mover #(.WORDS(WORDS), .MEM_AW(MEM_AW)) u_mover (
        .clk(clk), .rst(rst),
        .start_pull(start_pull), .start_push(start_push),
        .base(base_q[MEM_AW-1:0]), .cmd_done(cmd_done),
        .ram_rword(dma_rword), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .busy(busy), .done(done), .snap_en(snap_en), .cmd_go(cmd_go),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .idx(dma_idx), .dma_wr(dma_wr), .dma_wdata(dma_wdata)
    );

    sidma_ram #(.WORDS(WORDS)) u_ram (
        .clk(clk), .rst(rst),
        .host_wr(ram_wr), .host_idx(ram_idx), .host_wdata(host_wdata), .host_keep(host_bmask),
        .dma_wr(dma_wr), .dma_idx(dma_idx), .dma_wdata(dma_wdata),
        .cmd_wr(cmd_wr && cmd_go), .cmd_idx(cmd_widx), .cmd_wdata(cmd_wdata),
        .snap_en(snap_en), .host_rword(host_rword), .dma_rword(dma_rword), .snap(cmd_snap)
    );
endmodule

// File: tb/sidma_ctrl_tb.sv
module sidma_ctrl_tb_top;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         host_req = 0, host_we = 0, host_sel = 0;
    logic [31:0]  host_addr = 0, host_wdata = 0;
    logic [3:0]   host_bmask = 0;
    logic [31:0]  host_rdata;
    logic         host_rvalid, irq, mem_req, mem_we, cmd_go;
    logic [28:0]  mem_addr;
    logic [31:0]  mem_wdata;
    logic [31:0]  mem_rdata = 0;
    logic         mem_ack = 0;
    logic         cmd_done = 0, cmd_wr = 0;
    logic [3:0]   cmd_widx = 0;
    logic [31:0]  cmd_wdata = 0;
    logic [511:0] cmd_snap;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    sidma_ctrl dut_i (
        .clk(clk), .rst(rst), .host_req(host_req), .host_we(host_we), .host_sel(host_sel),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_bmask(host_bmask),
        .host_rdata(host_rdata), .host_rvalid(host_rvalid), .irq(irq),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack), .cmd_go(cmd_go), .cmd_done(cmd_done),
        .cmd_wr(cmd_wr), .cmd_widx(cmd_widx), .cmd_wdata(cmd_wdata), .cmd_snap(cmd_snap)
    );

    // Memory model: acknowledges every other cycle, checks address order.
    logic [31:0] sysmem [256];
    int rd_cnt = 0, wr_cnt = 0, addr_err = 0;
    logic [28:0] exp_addr = 0;
    always @(negedge clk) begin
        if (mem_ack) mem_ack = 1'b0;
        else if (mem_req) begin
            mem_ack = 1'b1;
            if (mem_addr != exp_addr) addr_err++;
            exp_addr = exp_addr + 29'd4;
            if (mem_we) begin
                sysmem[mem_addr[9:2]] = mem_wdata;
                wr_cnt++;
            end else begin
                mem_rdata = sysmem[mem_addr[9:2]];
                rd_cnt++;
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic hwr(input logic sel, input logic [31:0] a, input logic [31:0] d, input logic [3:0] m);
        @(negedge clk);
        host_req = 1; host_we = 1; host_sel = sel; host_addr = a; host_wdata = d; host_bmask = m;
        @(negedge clk);
        host_req = 0; host_we = 0;
    endtask

    task automatic hrd(input logic sel, input logic [31:0] a, output logic [31:0] d);
        @(negedge clk);
        host_req = 1; host_we = 0; host_sel = sel; host_addr = a;
        @(negedge clk);
        host_req = 0;
        d = host_rdata;
        check("R5 rvalid", {31'h0, host_rvalid}, 32'h1);
    endtask

    task automatic wait_irq();
        for (int i = 0; i < 400 && !irq; i++) @(negedge clk);
    endtask

    function automatic logic [31:0] pat(input int k);
        return 32'hA1B2C3D4 + k;
    endfunction

    // {write addr, write data, keep mask, read addr, expected word}
    localparam logic [131:0] VEC [4] = '{
        {32'h0000_0010, 32'h1122_3344, 4'b0000, 32'h0000_0010, 32'h1122_3344},
        {32'h0000_0050, 32'hAABB_CCDD, 4'b1010, 32'h0000_00D0, 32'h11BB_33DD},
        {32'h0000_0010, 32'h5566_7788, 4'b0111, 32'h0000_0010, 32'h55BB_33DD},
        {32'hFFFF_FF90, 32'hFFFF_FFFF, 4'b1111, 32'h0000_0010, 32'h55BB_33DD}
    };

    initial begin
        logic [31:0] d;
        for (int i = 0; i < 256; i++) sysmem[i] = 32'h0;
        for (int k = 0; k < 16; k++) sysmem[16 + k] = pat(k);
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R1 reset state
        check("R1 irq", {31'h0, irq}, 32'h0);
        check("R1 mem_req", {31'h0, mem_req}, 32'h0);
        hrd(0, 32'hC, d); check("R1 status", d, 32'h0);
        hrd(1, 32'h3C, d); check("R1 status byte", d, 32'h0);

        // R3/R4 table of masked RAM writes
        for (int v = 0; v < 4; v++) begin
            hwr(0, 32'hC, 32'h0, 4'h0);
            hwr(1, VEC[v][131:100], VEC[v][99:68], VEC[v][67:64]);
            check("R3 pending after RAM write", {31'h0, irq}, 32'h1);
            hrd(1, VEC[v][63:32], d);
            check("R3 R4 merged word", d, VEC[v][31:0]);
        end

        // R2 status write with any data clears
        hwr(0, 32'hC, 32'h0, 4'h0);
        check("R2 clear zero data", {31'h0, irq}, 32'h0);
        hwr(1, 32'h0, 32'h0, 4'h0);
        hwr(0, 32'hC, 32'hFFFF_FFFF, 4'hF);
        check("R2 clear ones data", {31'h0, irq}, 32'h0);
        hrd(0, 32'hC, d); check("R2 status bit12 clear", d, 32'h0);

        // R9 base register byte replace
        hwr(0, 32'h0, 32'hE000_0040, 4'hF);
        hrd(0, 32'h0, d); check("R9 base full", d, 32'hE000_0040);
        hwr(0, 32'h0, 32'h1234_5678, 4'b0001);
        hrd(0, 32'h0, d); check("R9 base lane0", d, 32'hE000_0078);
        hwr(0, 32'h0, 32'h0000_0040, 4'b0001);
        hrd(0, 32'h4, d); check("R9 trigger reads 0", d, 32'h0);

        // R5 side-effect offsets
        hwr(1, 32'h24, 32'h0A0B_0C0D, 4'h0);
        hrd(1, 32'h24, d); check("R5 read 0x24 word", d, 32'h0A0B_0C0D);
        hrd(1, 32'h3C, d); check("R5 status byte armed", d, 32'h80);
        hwr(1, 32'h3C, 32'h1234_5678, 4'h0);
        hrd(1, 32'h3C, d); check("R5 0x3C hides RAM", d, 32'h80);

        // R6 pull: base 0xE0000040 masked to 0x40
        hwr(0, 32'hC, 32'h0, 4'h0);
        rd_cnt = 0; wr_cnt = 0; addr_err = 0; exp_addr = 29'h40;
        hwr(0, 32'h4, 32'h0, 4'h0);
        check("R6 request starts", {31'h0, mem_req}, 32'h1);
        wait_irq();
        check("R6 irq at end", {31'h0, irq}, 32'h1);
        check("R6 read count", rd_cnt, 32'd16);
        check("R6 no writes", wr_cnt, 32'd0);
        check("R6 R10 address order", addr_err, 32'd0);
        hrd(1, 32'h0, d); check("R6 word0", d, pat(0));
        hrd(1, 32'h54, d); check("R6 word5", d, pat(5));
        hrd(1, 32'h38, d); check("R6 word14", d, pat(14));
        check("R6 snapshot word0", cmd_snap[511:480], pat(0));
        check("R6 snapshot word15", cmd_snap[31:0], pat(15));
        check("R4 snapshot byte0", {24'h0, cmd_snap[511:504]}, 32'hA1);
        hrd(0, 32'hC, d); check("R6 status pend idle", d, 32'h1000);

        // R7/R8 push with command phase
        hwr(0, 32'hC, 32'h0, 4'h0);
        for (int k = 0; k < 16; k++) sysmem[16 + k] = 32'h0;
        rd_cnt = 0; wr_cnt = 0; addr_err = 0; exp_addr = 29'h40;
        hwr(0, 32'h8, 32'h0, 4'h0);
        check("R7 cmd_go", {31'h0, cmd_go}, 32'h1);
        hwr(0, 32'h4, 32'h0, 4'h0);
        hwr(1, 32'h4, 32'h9999_9999, 4'h0);
        hrd(0, 32'hC, d); check("R8 busy no pend", d, 32'h1);
        check("R7 no memory traffic", {31'h0, mem_req}, 32'h0);
        @(negedge clk); cmd_wr = 1; cmd_widx = 4'd0; cmd_wdata = 32'hCAFE_F00D;
        @(negedge clk); cmd_wr = 0; cmd_done = 1;
        @(negedge clk); cmd_done = 0;
        wait_irq();
        check("R7 irq at end", {31'h0, irq}, 32'h1);
        check("R7 write count", wr_cnt, 32'd16);
        check("R8 pull ignored", rd_cnt, 32'd0);
        check("R7 R10 address order", addr_err, 32'd0);
        check("R7 word0 processor", sysmem[16], 32'hCAFE_F00D);
        check("R3 busy RAM write ignored", sysmem[17], pat(1));
        check("R7 word15", sysmem[31], pat(15));
        hrd(0, 32'hC, d); check("R8 idle after push", d, 32'h1000);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog R1 actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule